// File: doc/BRIEF.md
# Scheduled Two-Input Time-Multiplexed Switch

This block is one switching point of a statically routed overlay network. Every route through it is settled before the network starts, and the outcome is held in a small context store with one select bit and one valid bit for each time slot. While the switch runs, a slot counter walks through the store. The entry for the current slot decides which of the two data inputs is passed on, or marks the slot as idle. The switch never looks at the data, never queues it and never arbitrates between inputs.

Configuration software loads the store through a write port, but only while the switch is halted. It sets the index of the last slot of the schedule and then raises `run`. From then on the schedule repeats without further attention. Lowering `run` halts the switch and sends the counter back to slot 0, so every start replays the schedule from its beginning.

Top module: `tm_sched_switch`

## Requirements
- R1: While `rst_n` is low and after it rises, `out_valid` is 0, `out_data` is 0 and the slot counter is at slot 0. Every context entry is cleared to invalid.
- R2: For a context entry with valid=1 and select=0, the value on `in_a` at the clock edge that processes that slot appears on `out_data` after that edge, with `out_valid`=1.
- R3: For a context entry with valid=1 and select=1, the value on `in_b` at that edge appears on `out_data` after that edge, with `out_valid`=1.
- R4: In a slot whose entry has valid=0, `out_valid` is 0 after that edge and `out_data` keeps its previous value.
- R5: While `run` is high, the counter advances by one slot per cycle. After slot `slot_last` it returns to slot 0, so the schedule has a period of `slot_last`+1 cycles.
- R6: A configuration write (`cfg_we`=1) at an edge where `run` is high leaves the context store unchanged. A write while `run` is low stores {`cfg_vld`, `cfg_sel`} at `cfg_addr`.
- R7: At an edge where `run` is low, `out_valid` goes to 0, `out_data` holds, and the counter returns to slot 0. The next run begins at slot 0.
- R8: With `slot_last`=DEPTH-1 (63), all 64 entries take part in the schedule and each is replayed in order.
- R9: An entry that has not been written since reset behaves as an idle slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | High to step the schedule, low to halt and rewind |
| slot_last | input | 6 | Index of the final slot of the schedule; held stable while running |
| cfg_we | input | 1 | Context write strobe, honoured only while halted |
| cfg_addr | input | 6 | Slot index being written |
| cfg_vld | input | 1 | Valid bit for the written slot |
| cfg_sel | input | 1 | Select bit for the written slot (0 = `in_a`, 1 = `in_b`) |
| in_a | input | 16 | Data input 0 |
| in_b | input | 16 | Data input 1 |
| out_data | output | 16 | Registered switched data |
| out_valid | output | 1 | High when `out_data` carries data from a valid slot |

## Verification
Every result is due exactly one clock edge after the slot that produces it. The output register is the only stage between the inputs and the ports. The bench changes the data inputs at a falling edge and works out the expected output from its own copy of the schedule and its own slot count. It then waits for one rising edge and compares at the following falling edge. Halts, and writes attempted while running, are judged the same way: `out_valid` is checked one edge after `run` falls, and an ignored write is checked by watching the affected slot on its next pass through the schedule.

// File: rtl/tm_sched_switch.sv
module tm_sched_switch #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [AW-1:0]     slot_last,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic              cfg_vld,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid
);

  logic [DEPTH-1:0] ctx_vld, ctx_sel;
  logic [AW-1:0]    slot;
  logic             cur_vld, cur_sel;

  assign cur_vld = ctx_vld[slot];
  assign cur_sel = ctx_sel[slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx_vld <= '0;
      ctx_sel <= '0;
    end else if (cfg_we && !run) begin
      ctx_vld[cfg_addr] <= cfg_vld;
      ctx_sel[cfg_addr] <= cfg_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run)          slot <= '0;
    else if (slot == slot_last)  slot <= '0;
    else                         slot <= slot + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= run && cur_vld;
      if (run && cur_vld) out_data <= cur_sel ? in_b : in_a;
    end
  end

  a_r2_pass_a: assert property (@(posedge clk) disable iff (!rst_n)
    run && cur_vld && !cur_sel |=> out_valid && out_data == $past(in_a));
  a_r3_pass_b: assert property (@(posedge clk) disable iff (!rst_n)
    run && cur_vld && cur_sel |=> out_valid && out_data == $past(in_b));
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    run && !cur_vld |=> !out_valid && $stable(out_data));
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    run && slot == slot_last |=> slot == '0);
  a_r6_frozen_ctx: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(ctx_vld) && $stable(ctx_sel));
  a_r7_halt: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !out_valid && slot == '0 && $stable(out_data));

endmodule

// File: tb/tm_sched_switch_test.sv
module tm_sched_switch_test;
  logic        clk = 0, rst_n = 0, run = 0;
  logic [5:0]  slot_last = 0, cfg_addr = 0;
  logic        cfg_we = 0, cfg_vld = 0, cfg_sel = 0;
  logic [15:0] in_a = 0, in_b = 0, out_data;
  logic        out_valid;

  int checks = 0, fails = 0;
  bit m_vld [64];
  bit m_sel [64];
  logic [15:0] exp_data = 0;
  int cyc = 0;

  tm_sched_switch uut (.clk, .rst_n, .run, .slot_last, .cfg_we, .cfg_addr,
    .cfg_vld, .cfg_sel, .in_a, .in_b, .out_data, .out_valid);

  always #5 clk = ~clk;

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic write_entry(int a, bit v, bit s);
    cfg_we = 1; cfg_addr = a[5:0]; cfg_vld = v; cfg_sel = s;
    @(posedge clk); @(negedge clk);
    cfg_we = 0;
    m_vld[a] = v; m_sel[a] = s;
  endtask

  // runs n cycles from slot 0; poke_at >= 0 attempts an overwrite of slot 0 then
  task automatic run_sched(int n, int last, int poke_at, string req);
    int s = 0;
    bit ev;
    slot_last = last[5:0];
    run = 1;
    for (int i = 0; i < n; i++) begin
      cyc++;
      in_a = 16'h1000 + cyc[15:0];
      in_b = 16'h8000 + cyc[15:0];
      if (i == poke_at) begin
        cfg_we = 1; cfg_addr = 0; cfg_vld = !m_vld[0]; cfg_sel = !m_sel[0];
      end
      ev = m_vld[s];
      if (ev) exp_data = m_sel[s] ? in_b : in_a;
      @(posedge clk); @(negedge clk);
      cfg_we = 0;
      check(req, {15'd0, out_valid}, {15'd0, ev});
      check(req, out_data, exp_data);
      s = (s == last) ? 0 : s + 1;
    end
    run = 0;
    @(posedge clk); @(negedge clk);
    check("R7", {15'd0, out_valid}, 16'd0);
    check("R7", out_data, exp_data);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1", {15'd0, out_valid}, 16'd0);
    check("R1", out_data, 16'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1", {15'd0, out_valid}, 16'd0);
    run_sched(4, 3, -1, "R9");
  endtask

  task automatic t_basic;
    write_entry(0, 1, 0);
    write_entry(1, 1, 1);
    write_entry(2, 0, 1);
    write_entry(3, 1, 0);
    run_sched(11, 3, -1, "R2_R3_R4_R5");
    run_sched(3, 3, -1, "R7");
  endtask

  task automatic t_cfg_locked;
    run_sched(9, 3, 1, "R6");
    write_entry(0, 1, 1);
    run_sched(5, 3, -1, "R6");
  endtask

  task automatic t_full;
    for (int a = 0; a < 64; a++) write_entry(a, (a % 5) != 0, (a % 3) == 0);
    run_sched(140, 63, -1, "R8");
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_basic;
    t_cfg_locked;
    t_full;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule